// File: doc/BRIEF.md
# I2C Standard-Speed SCL High-Count Register with Bus-Idle Detector

This block stores the SCL high-period count that an I2C controller uses in standard speed, and uses the same count to decide when the bus has gone idle. Software programs the count through a simple write port. A parameter sets the port to 16 bits, where one write loads the value, or to 8 bits, where two byte-lane writes load it. The value can only be changed while the controller is disabled. Any value below the legal minimum is raised to that minimum before it is stored.

A 16-bit idle counter watches the synchronized SCL and SDA levels. It counts clocks while both lines are high. It raises the bus-idle flag once the count reaches the programmed high count plus a fixed margin. The flag drops in the same cycle that either line goes low. Supported high counts run up to 65525, so that the threshold still fits in 16 bits.

Top module: `scl_hcnt_idle`

## Requirements
- R1: After reset, `hcnt_o` reads the default count 40 and `bus_idle_o` is 0, even when both lines are high.
- R2: With `BUS_W`=16 and `ctrl_en_i`=0, a cycle with `wr_en_i`=1 stores `wr_data_i`, and `hcnt_o` shows the value after that clock edge. `wr_hi_i` is ignored.
- R3: While `ctrl_en_i`=1, any write leaves `hcnt_o` unchanged. In 8-bit mode such a write also leaves the staged low byte unchanged.
- R4: A write whose value is below 6 stores 6. The value 6 and larger values, up to 65525, are stored as written. In 8-bit mode the check applies to the combined 16-bit value.
- R5: With `BUS_W`=8, a write with `wr_hi_i`=0 stages bits 7:0 and leaves `hcnt_o` unchanged. A later write with `wr_hi_i`=1 commits {`wr_data_i`, staged byte} as bits 15:8 and 7:0. The staged byte is kept after the commit.
- R6: The idle counter clears whenever SCL or SDA is low. It counts one per clock edge while both lines are high.
- R7: `bus_idle_o` rises after the clock edge on which the count of consecutive both-high edges reaches `hcnt_o`+10. It stays high while both lines remain high.
- R8: `bus_idle_o` drops in the same cycle that SCL or SDA goes low, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_en_i | input | 1 | Controller enable; 1 locks the register |
| wr_en_i | input | 1 | Register write strobe |
| wr_hi_i | input | 1 | In 8-bit mode, selects the byte lane (0 = low, 1 = high) |
| wr_data_i | input | BUS_W | Write data |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| hcnt_o | output | 16 | Committed high-period count |
| bus_idle_o | output | 1 | Bus-idle flag |

## Verification
The hardest case to reach is the 8-bit commit of a byte that was staged earlier while a locked low-byte write falls between the two lanes. The bench stages a low byte, attempts a low-byte write with the controller enabled, and then commits the high lane. The committed value shows whether the staged byte survived the locked write. On the idle side, the stimulus interrupts a long run of both-high cycles with a single low cycle. It then counts the full threshold again from zero, checking one edge before and exactly at the edge where the flag must rise.

// File: rtl/scl_idle_pkg.sv
package scl_idle_pkg;
  localparam int CNT_W = 16;

  function automatic logic [CNT_W-1:0] clamp_min(input logic [CNT_W-1:0] val,
                                                 input logic [CNT_W-1:0] floor_val);
    return (val < floor_val) ? floor_val : val;
  endfunction
endpackage

// File: rtl/scl_hcnt_store.sv
module scl_hcnt_store
  import scl_idle_pkg::*;
#(
  parameter int BUS_W   = 16,
  parameter int MIN_CNT = 6,
  parameter int RST_CNT = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             wr_en_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] hcnt_o
);
  localparam logic [CNT_W-1:0] MinVal = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] RstVal = CNT_W'(RST_CNT);

  logic [CNT_W-1:0] hcnt_q;
  logic             wr_ok;

  assign wr_ok  = wr_en_i & ~lock_i;
  assign hcnt_o = hcnt_q;

  generate
    if (BUS_W >= CNT_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = wr_hi_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    hcnt_q <= RstVal;
        else if (wr_ok) hcnt_q <= clamp_min(wr_data_i[CNT_W-1:0], MinVal);
      end
    end else begin : g_byte
      logic [BUS_W-1:0] stage_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                stage_q <= '0;
        else if (wr_ok && !wr_hi_i) stage_q <= wr_data_i;
      end

      // commit happens only on the high lane, so the register never shows a half-written value
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               hcnt_q <= RstVal;
        else if (wr_ok && wr_hi_i) hcnt_q <= clamp_min(CNT_W'({wr_data_i, stage_q}), MinVal);
      end

      AST_LOW_LANE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_hi_i) |=> $stable(hcnt_q)); // R5
    end
  endgenerate

  AST_LOCKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(hcnt_q)); // R3
  AST_MIN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q >= MinVal); // R4
endmodule

// File: rtl/scl_idle_detect.sv
module scl_idle_detect
  import scl_idle_pkg::*;
#(
  parameter int IDLE_MARGIN = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [CNT_W-1:0] hcnt_i,
  output logic             idle_o
);
  localparam logic [CNT_W-1:0] Margin = CNT_W'(IDLE_MARGIN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;
  logic             lines_hi;

  assign thr      = hcnt_i + Margin;
  assign lines_hi = scl_i & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!lines_hi)   cnt_q <= '0;
    else if (cnt_q < thr) cnt_q <= cnt_q + 1'b1;
  end

  // line gating keeps the flag combinational on the falling edge of either line
  assign idle_o = (cnt_q >= thr) & lines_hi;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lines_hi |=> (cnt_q == '0)); // R6
  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lines_hi && cnt_q >= thr) |=> (cnt_q == $past(cnt_q))); // R7
endmodule

// File: rtl/scl_hcnt_idle.sv
module scl_hcnt_idle
  import scl_idle_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int MIN_CNT     = 6,
  parameter int RST_CNT     = 40,
  parameter int IDLE_MARGIN = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_en_i,
  input  logic             wr_en_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic [15:0]      hcnt_o,
  output logic             bus_idle_o
);
  logic [CNT_W-1:0] hcnt;

  scl_hcnt_store #(
    .BUS_W  (BUS_W),
    .MIN_CNT(MIN_CNT),
    .RST_CNT(RST_CNT)
  ) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (ctrl_en_i),
    .wr_en_i  (wr_en_i),
    .wr_hi_i  (wr_hi_i),
    .wr_data_i(wr_data_i),
    .hcnt_o   (hcnt)
  );

  scl_idle_detect #(
    .IDLE_MARGIN(IDLE_MARGIN)
  ) i_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .hcnt_i(hcnt),
    .idle_o(bus_idle_o)
  );

  assign hcnt_o = hcnt;
endmodule

// File: tb/test_scl_hcnt_idle.sv
module test_scl_hcnt_idle;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;
  localparam int NVEC  = 9;
  // {ctrl_en, write data, expected hcnt_o}
  localparam logic [32:0] VECS [NVEC] = '{
    {1'b0, 16'd100,   16'd100},
    {1'b0, 16'd5,     16'd6},
    {1'b0, 16'd0,     16'd6},
    {1'b1, 16'd200,   16'd6},
    {1'b0, 16'd7,     16'd7},
    {1'b1, 16'd3,     16'd7},
    {1'b0, 16'd65525, 16'd65525},
    {1'b0, 16'd6,     16'd6},
    {1'b0, 16'd1234,  16'd1234}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic ctrl16 = 1'b0, we16 = 1'b0, hi16 = 1'b0;
  logic [15:0] d16 = '0;
  logic ctrl8 = 1'b0, we8 = 1'b0, hi8 = 1'b0;
  logic [7:0] d8 = '0;
  logic [15:0] hcnt16, hcnt8;
  logic idle16, idle8;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  scl_hcnt_idle i_scl_hcnt_idle (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(ctrl16), .wr_en_i(we16), .wr_hi_i(hi16),
    .wr_data_i(d16), .scl_i(scl), .sda_i(sda), .hcnt_o(hcnt16), .bus_idle_o(idle16));

  scl_hcnt_idle #(.BUS_W(8)) i_scl_hcnt_idle_b8 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(ctrl8), .wr_en_i(we8), .wr_hi_i(hi8),
    .wr_data_i(d8), .scl_i(scl), .sda_i(sda), .hcnt_o(hcnt8), .bus_idle_o(idle8));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr16(input logic en, input logic [15:0] val);
    ctrl16 = en; we16 = 1'b1; d16 = val;
    tick();
    we16 = 1'b0; ctrl16 = 1'b0;
  endtask

  task automatic wr8(input logic en, input logic hi, input logic [7:0] val);
    ctrl8 = en; we8 = 1'b1; hi8 = hi; d8 = val;
    tick();
    we8 = 1'b0; ctrl8 = 1'b0;
  endtask

  initial begin
    #(CLK_P * WDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2);
    // R1: reset state with both lines high
    chk("R1 hcnt16", hcnt16, 16'd40);
    chk("R1 hcnt8", hcnt8, 16'd40);
    chk("R1 idle", {15'd0, idle16}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    scl = 1'b0;
    tick();

    // R2 R3 R4: vector table on the 16-bit port, wr_hi_i toggled to show it is ignored
    for (int i = 0; i < NVEC; i++) begin
      hi16 = i[0];
      wr16(VECS[i][32], VECS[i][31:16]);
      chk("R2/R3/R4 vector", hcnt16, VECS[i][15:0]);
    end

    // R5: 8-bit lanes
    wr8(1'b0, 1'b0, 8'h34);
    chk("R5 low lane not committed", hcnt8, 16'd40);
    wr8(1'b0, 1'b1, 8'h12);
    chk("R5 commit", hcnt8, 16'h1234);
    wr8(1'b0, 1'b0, 8'h03);
    wr8(1'b0, 1'b1, 8'h00);
    chk("R4 8-bit clamp", hcnt8, 16'd6);
    wr8(1'b1, 1'b0, 8'hAA);
    chk("R3 locked low lane", hcnt8, 16'd6);
    wr8(1'b1, 1'b1, 8'h55);
    chk("R3 locked high lane", hcnt8, 16'd6);
    wr8(1'b0, 1'b1, 8'h01);
    chk("R3/R5 staged byte kept", hcnt8, 16'h0103);

    // R6 R7 R8: hcnt16 = 6, threshold 16
    wr16(1'b0, 16'd6);
    chk("R4 min value", hcnt16, 16'd6);
    scl = 1'b1; sda = 1'b1;
    repeat (10) tick();
    scl = 1'b0;
    tick();
    chk("R6 cleared, no idle", {15'd0, idle16}, 16'd0);
    scl = 1'b1;
    repeat (15) tick();
    chk("R6 restart from zero, 15 edges", {15'd0, idle16}, 16'd0);
    tick();
    chk("R7 idle at threshold", {15'd0, idle16}, 16'd1);
    repeat (5) tick();
    chk("R7 idle held", {15'd0, idle16}, 16'd1);
    sda = 1'b0;
    #1;
    chk("R8 immediate drop on sda", {15'd0, idle16}, 16'd0);
    tick();
    sda = 1'b1;
    repeat (16) tick();
    chk("R7 idle again", {15'd0, idle16}, 16'd1);
    scl = 1'b0;
    #1;
    chk("R8 immediate drop on scl", {15'd0, idle16}, 16'd0);
    scl = 1'b1;

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async reset hcnt", hcnt16, 16'd40);
    chk("R1 async reset idle", {15'd0, idle16}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 reset hcnt8", hcnt8, 16'd40);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule